// File: doc/BRIEF.md
# Validating Ethernet Ingress Frame Buffer

This block sits at the input of one switch port. It takes a byte stream of Ethernet frames in the port clock domain and stores them in a dual-clock buffer. The buffer holds at least one maximum-size frame. Each frame is checked once its final byte has arrived. The check covers the total length and the trailing frame check sequence. Only frames that pass are handed to the switch core clock domain. A frame that fails, is aborted, or does not fit is erased in one step by moving the write pointer back to the frame's first byte, so the core never sees any of its bytes.

The input side has no back-pressure. A byte presented with `in_valid` high is always consumed, and a frame that finds the buffer full is dropped. The output side is a valid/ready stream. A byte transfers on a `rclk` edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the byte and its last marker are held unchanged. Frames shorter than the usual 64-byte minimum are kept if they carry a whole header and a correct check sequence.

Top module: `eth_frame_ingress_fifo`

## Requirements
- R1: A frame whose length is within limits and whose check sequence is correct appears at the output complete and in order. All of its bytes are delivered, check sequence included, and `out_last` is high on its final byte only. The check sequence is the bit-reflected CRC-32 (polynomial 0x04C11DB7, preset all ones, result inverted), appended least significant byte first.
- R2: A frame with a wrong check sequence produces no output byte, and the frame after it is delivered normally.
- R3: A beat with `in_valid` and `in_abort` both high discards the frame in progress, including that beat's byte. Nothing of that frame is output.
- R4: The minimum length is 18 bytes (14-byte header plus 4-byte check sequence). A frame of 17 bytes or fewer is dropped. A frame of 18 to 63 bytes with a correct check sequence is delivered.
- R5: The maximum length is `STD_MAX_LEN` (1518 bytes by default), or `JUMBO_MAX_LEN` when `ALLOW_JUMBO` is set and the buffer holds at least that many bytes. A frame at the maximum is delivered, and a frame one byte longer is dropped.
- R6: A frame that meets a full buffer before its last byte is dropped whole, and earlier stored frames are not affected. Intake resumes with the next frame.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` stay unchanged. No byte is lost or repeated under back-pressure.
- R8: No byte of a frame reaches the output before that frame's final byte has been accepted. Pointers that cross between the clock domains change by at most one Gray-code bit per source clock.
- R9: After reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Port-side clock |
| wrst_n | input | 1 | Asynchronous active-low reset, port side |
| in_data | input | 8 | Frame byte |
| in_valid | input | 1 | Byte present this cycle |
| in_last | input | 1 | Final byte of the frame |
| in_abort | input | 1 | Discard the current frame (qualified by in_valid) |
| rclk | input | 1 | Switch core clock |
| rrst_n | input | 1 | Asynchronous active-low reset, core side |
| out_data | output | 8 | Released frame byte |
| out_valid | output | 1 | out_data holds a byte of a validated frame |
| out_last | output | 1 | out_data is a frame's final byte |
| out_ready | input | 1 | Core accepts the byte this cycle |

## Verification
Good frames of 18, 64, 100 and 1518 bytes show that delivery is exact across the whole length range. A single flipped byte, a 17-byte and a 10-byte frame, a 1519-byte frame and a mid-frame abort each isolate one drop rule. In each of these cases a good frame sent afterwards shows that the pointers were restored correctly. Two frames written with the reader stalled separate overflow handling from the length check. Holding a frame back before its last byte shows whether data is released early. A throttled reader shows whether bytes are held steady under back-pressure.

// File: rtl/eifo_pkg.sv
package eifo_pkg;
  localparam logic [31:0] FCS_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] FCS_PRESET    = 32'hFFFFFFFF;
  localparam logic [31:0] FCS_GOOD_REM  = 32'hDEBB20E3;
  localparam int          HDR_BYTES     = 14;
  localparam int          FCS_BYTES     = 4;

  function automatic logic [31:0] fcs_step(input logic [31:0] cur, input logic [7:0] b);
    logic [31:0] r;
    r = cur ^ {24'd0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ FCS_POLY_REFL) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/eifo_fcs.sv
module eifo_fcs
  import eifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       restart,
  input  logic [7:0] data,
  output logic       good
);
  logic [31:0] acc_q, acc_nxt;

  assign acc_nxt = fcs_step(acc_q, data);
  assign good    = (acc_nxt == FCS_GOOD_REM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= FCS_PRESET;
    else if (en)      acc_q <= restart ? FCS_PRESET : acc_nxt;
  end
endmodule

// File: rtl/eifo_ptr_cdc.sv
module eifo_ptr_cdc #(
  parameter int W = 12
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic [W-1:0] src_bin,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic [W-1:0] dst_bin
);
  logic [W-1:0] gray_q, meta_q, sync_q;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) gray_q <= '0;
    else            gray_q <= src_bin ^ (src_bin >> 1);
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_q;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) dst_bin[i] = ^(sync_q >> i);
  end

  AST_GRAY_ONE_STEP: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    $countones(gray_q ^ $past(gray_q)) <= 1); // R8
endmodule

// File: rtl/eifo_ram.sv
module eifo_ram #(
  parameter int AW = 11,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int ENTRIES = 1 << AW;
  logic [DW-1:0] cells [ENTRIES];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/eth_frame_ingress_fifo.sv
module eth_frame_ingress_fifo
  import eifo_pkg::*;
#(
  parameter int ADDR_W        = 11,
  parameter bit ALLOW_JUMBO   = 1'b0,
  parameter int STD_MAX_LEN   = 1518,
  parameter int JUMBO_MAX_LEN = 9018
) (
  input  logic       wclk,
  input  logic       wrst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  input  logic       in_abort,
  input  logic       rclk,
  input  logic       rrst_n,
  output logic [7:0] out_data,
  output logic       out_valid,
  output logic       out_last,
  input  logic       out_ready
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int PW      = ADDR_W + 1;
  localparam int MIN_LEN = HDR_BYTES + FCS_BYTES;
  localparam int MAX_LEN = (ALLOW_JUMBO && DEPTH >= JUMBO_MAX_LEN) ? JUMBO_MAX_LEN : STD_MAX_LEN;
  localparam int LEN_W   = $clog2(MAX_LEN + 2);
  localparam logic [LEN_W-1:0] LEN_SAT = LEN_W'(MAX_LEN + 1);

  // ---------------- write (port) domain ----------------
  logic [PW-1:0]    wr_ptr, commit_ptr, pub_ptr, rptr_ws, occupancy;
  logic [LEN_W-1:0] len_q, len_total;
  logic             dropping, full, store, fcs_good, frame_good;

  assign occupancy  = wr_ptr - rptr_ws;
  assign full       = (occupancy == PW'(DEPTH));
  assign store      = in_valid && !in_abort && !dropping && !full;
  assign len_total  = (len_q == LEN_SAT) ? len_q : len_q + 1'b1;
  assign frame_good = fcs_good && (len_total >= LEN_W'(MIN_LEN)) && (len_total <= LEN_W'(MAX_LEN));

  eifo_fcs u_fcs (
    .clk     (wclk),
    .rst_n   (wrst_n),
    .en      (in_valid),
    .restart (in_last || in_abort),
    .data    (in_data),
    .good    (fcs_good)
  );

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wr_ptr     <= '0;
      commit_ptr <= '0;
      pub_ptr    <= '0;
      len_q      <= '0;
      dropping   <= 1'b0;
    end else begin
      if (pub_ptr != commit_ptr) pub_ptr <= pub_ptr + 1'b1;
      if (in_valid) begin
        if (in_abort || in_last)  len_q <= '0;
        else if (len_q != LEN_SAT) len_q <= len_q + 1'b1;

        if (in_abort) begin
          wr_ptr   <= commit_ptr;
          dropping <= 1'b0;
        end else if (dropping || full) begin
          wr_ptr   <= commit_ptr;
          dropping <= !in_last;
        end else if (in_last) begin
          if (frame_good) begin
            wr_ptr     <= wr_ptr + 1'b1;
            commit_ptr <= wr_ptr + 1'b1;
          end else begin
            wr_ptr <= commit_ptr;
          end
        end else begin
          wr_ptr <= wr_ptr + 1'b1;
        end
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_ptr - rptr_ws) <= PW'(DEPTH)); // R6
  AST_ABORT_ROLLBACK: assert property (@(posedge wclk) disable iff (!wrst_n)
    (in_valid && in_abort) |=> (wr_ptr == commit_ptr)); // R3
  AST_PUB_BEHIND_COMMIT: assert property (@(posedge wclk) disable iff (!wrst_n)
    (commit_ptr - pub_ptr) <= PW'(DEPTH)); // R8

  // ---------------- storage ----------------
  logic [8:0]    rd_word;
  logic [PW-1:0] rd_ptr, pub_rs;

  eifo_ram #(.AW(ADDR_W), .DW(9)) u_ram (
    .wclk  (wclk),
    .we    (store),
    .waddr (wr_ptr[ADDR_W-1:0]),
    .wdata ({in_last, in_data}),
    .raddr (rd_ptr[ADDR_W-1:0]),
    .rdata (rd_word)
  );

  // ---------------- pointer crossings ----------------
  eifo_ptr_cdc #(.W(PW)) u_pub_x (
    .src_clk   (wclk),
    .src_rst_n (wrst_n),
    .src_bin   (pub_ptr),
    .dst_clk   (rclk),
    .dst_rst_n (rrst_n),
    .dst_bin   (pub_rs)
  );

  eifo_ptr_cdc #(.W(PW)) u_rd_x (
    .src_clk   (rclk),
    .src_rst_n (rrst_n),
    .src_bin   (rd_ptr),
    .dst_clk   (wclk),
    .dst_rst_n (wrst_n),
    .dst_bin   (rptr_ws)
  );

  // ---------------- read (core) domain ----------------
  assign out_valid = (rd_ptr != pub_rs);
  assign out_data  = rd_word[7:0];
  assign out_last  = rd_word[8];

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)                    rd_ptr <= '0;
    else if (out_valid && out_ready) rd_ptr <= rd_ptr + 1'b1;
  end

  AST_HOLD_STALL: assert property (@(posedge rclk) disable iff (!rrst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R7
  AST_RD_BEHIND_PUB: assert property (@(posedge rclk) disable iff (!rrst_n)
    (pub_rs - rd_ptr) <= PW'(DEPTH)); // R6
endmodule

// File: tb/sim_eth_frame_ingress_fifo.sv
`timescale 1ns/1ps
module sim_eth_frame_ingress_fifo;
  localparam real CLK_PERIOD  = 10.0;
  localparam real RCLK_PERIOD = 14.0;

  logic       wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
  logic [7:0] in_data = 0;
  logic       in_valid = 0, in_last = 0, in_abort = 0;
  logic [7:0] out_data;
  logic       out_valid, out_last;
  logic       out_ready = 0;

  always #(CLK_PERIOD/2)  wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  eth_frame_ingress_fifo u0 (
    .wclk(wclk), .wrst_n(wrst_n), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_abort(in_abort), .rclk(rclk), .rrst_n(rrst_n),
    .out_data(out_data), .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready)
  );

  int checks = 0, errors = 0;
  int rmode = 1;       // 0 always ready, 1 never ready, 2 throttled
  int rcnt = 0, stall_err = 0;
  logic       prev_stall = 0;
  logic [8:0] prev_word = 0;
  logic [8:0] exp_q[$];
  logic [8:0] rx_q[$];
  logic [7:0] fb [0:2047];

  // collector: ready decided, then transfer recorded, away from the rclk edge
  always @(negedge rclk) begin
    logic rdy;
    rcnt++;
    if (prev_stall && (!out_valid || {out_last, out_data} != prev_word)) stall_err++;
    case (rmode)
      0: rdy = 1'b1;
      1: rdy = 1'b0;
      default: rdy = (rcnt % 3) != 0;
    endcase
    out_ready = rdy;
    if (out_valid && rdy) rx_q.push_back({out_last, out_data});
    prev_stall = out_valid && !rdy;
    prev_word  = {out_last, out_data};
  end

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb_bit = c[0] ^ fb[i][b];
        c = c >> 1;
        if (fb_bit) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  task automatic build(input int len, input bit corrupt, input int seed);
    logic [31:0] f;
    for (int i = 0; i < len - 4; i++) fb[i] = 8'(seed * 31 + i * 7 + (i >> 3));
    f = ref_crc(len - 4);
    for (int k = 0; k < 4; k++) fb[len - 4 + k] = f[8*k +: 8];
    if (corrupt) fb[len/2] = fb[len/2] ^ 8'h10;
  endtask

  task automatic expect_frame(input int len);
    for (int i = 0; i < len; i++) exp_q.push_back({(i == len - 1), fb[i]});
  endtask

  task automatic send_bytes(input int from, input int upto, input int len, input int abort_at);
    for (int i = from; i < upto; i++) begin
      @(negedge wclk);
      in_valid = 1; in_data = fb[i];
      in_last  = (i == len - 1);
      in_abort = (i == abort_at);
      if (i == abort_at) break;
    end
    @(negedge wclk);
    in_valid = 0; in_last = 0; in_abort = 0;
  endtask

  task automatic send(input int len);
    send_bytes(0, len, len, -1);
  endtask

  task automatic settle(input int len);
    repeat (3 * len + 200) @(negedge rclk);
  endtask

  task automatic check_rx(input string tag);
    int bad = -1;
    checks++;
    if (rx_q.size() != exp_q.size()) begin
      errors++;
      $display("FAIL %s: output byte count actual %0d expected %0d", tag, rx_q.size(), exp_q.size());
    end else begin
      foreach (rx_q[i]) if (bad < 0 && rx_q[i] !== exp_q[i]) bad = i;
      if (bad >= 0) begin
        errors++;
        $display("FAIL %s: byte %0d actual %h expected %h", tag, bad, rx_q[bad], exp_q[bad]);
      end
    end
    rx_q.delete(); exp_q.delete();
  endtask

  task automatic t_reset();
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9: out_valid actual %b expected 0", out_valid);
    end
  endtask

  task automatic t_good();
    rmode = 0;
    build(64, 0, 1);   expect_frame(64);   send(64);
    build(100, 0, 2);  expect_frame(100);  send(100);
    settle(200);
    check_rx("R1 good frames 64/100");
    build(1518, 0, 3); expect_frame(1518); send(1518);
    settle(1518);
    check_rx("R5 max length 1518 kept");
  endtask

  task automatic t_runt();
    rmode = 0;
    build(17, 0, 4); send(17);
    build(10, 0, 5); send(10);
    settle(50);
    check_rx("R4 below 18 bytes dropped");
    build(18, 0, 6); expect_frame(18); send(18);
    build(40, 0, 7); expect_frame(40); send(40);
    settle(80);
    check_rx("R4 short runts kept");
  endtask

  task automatic t_badfcs();
    rmode = 0;
    build(200, 1, 8); send(200);
    build(90, 0, 9);  expect_frame(90); send(90);
    settle(300);
    check_rx("R2 bad FCS dropped, next kept");
  endtask

  task automatic t_abort();
    rmode = 0;
    build(120, 0, 10); send_bytes(0, 120, 120, 50);
    build(70, 0, 11);  expect_frame(70); send(70);
    settle(200);
    check_rx("R3 abort discards frame");
  endtask

  task automatic t_long();
    rmode = 0;
    build(1519, 0, 12); send(1519);
    build(60, 0, 13);   expect_frame(60); send(60);
    settle(1600);
    check_rx("R5 over maximum dropped");
  endtask

  task automatic t_overflow();
    rmode = 1;
    build(1500, 0, 14); expect_frame(1500); send(1500);
    build(1000, 0, 15); send(1000);
    repeat (100) @(negedge rclk);
    rmode = 0;
    settle(1500);
    check_rx("R6 overflow frame dropped");
    build(200, 0, 16); expect_frame(200); send(200);
    settle(200);
    check_rx("R6 intake resumes");
  endtask

  task automatic t_early();
    rmode = 0;
    build(300, 0, 17); expect_frame(300);
    send_bytes(0, 299, 300, -1);
    repeat (100) @(negedge rclk);
    checks++;
    if (out_valid !== 1'b0 || rx_q.size() != 0) begin
      errors++;
      $display("FAIL R8: early output actual valid=%b bytes=%0d expected valid=0 bytes=0", out_valid, rx_q.size());
    end
    send_bytes(299, 300, 300, -1);
    settle(300);
    check_rx("R8 frame released after last byte");
  endtask

  task automatic t_backpressure();
    rmode = 2; stall_err = 0;
    build(150, 0, 18); expect_frame(150); send(150);
    build(33, 0, 19);  expect_frame(33);  send(33);
    build(260, 0, 20); expect_frame(260); send(260);
    settle(500);
    check_rx("R7 throttled reader");
    checks++;
    if (stall_err != 0) begin
      errors++;
      $display("FAIL R7: changes during stall actual %0d expected 0", stall_err);
    end
    rmode = 0;
  endtask

  initial begin
    repeat (190000) @(posedge wclk);
    errors++;
    $display("FAIL R1: watchdog expired, actual 190000 cycles expected fewer");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge rclk);
    wrst_n = 1; rrst_n = 1;
    repeat (3) @(negedge rclk);
    t_reset();
    t_good();
    t_runt();
    t_badfcs();
    t_abort();
    t_long();
    t_overflow();
    t_early();
    t_backpressure();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule